// File: doc/BRIEF.md
# Mobile DRAM Command Tracker

This block watches the decoded command stream of one four-bank low-power DDR memory device and keeps a cycle-accurate model of what the device is doing. Each bank has its own state: idle, row open, in a read or write burst, in a burst that precharges itself afterwards, or precharging. The block also tracks one device-wide state: power-on, ready, auto refresh, self refresh, deep power-down, and two power-down flavours. Any command that the device may not accept in its present state raises a one-cycle flag and is otherwise dropped.

A memory controller or a protocol monitor places the block beside the command bus. It feeds in the decoded command, the target bank and the clock-enable level each cycle. It reads back the per-bank and global state and the illegal-command flag. Leaving deep power-down emits a single-cycle pulse, which tells the controller that the device has lost its mode settings and must be initialised again. The block has no notion of timing parameters beyond the burst, precharge and refresh occupancy counts, and it moves no data.

All outputs change on the clock edge that samples the command.

Top module: `mddr_cmd_tracker`

## Requirements
- R1: After reset the global state is power-on (0), every bank is idle (0), and `illegal_o` and `mode_clr_o` are low. Global state codes are: power-on 0, ready 1, auto refresh 2, self refresh 3, deep power-down 4, precharge power-down 5, active power-down 6. Bank state codes are: idle 0, row open 1, read burst 2, write burst 3, read burst with auto precharge 4, write burst with auto precharge 5, precharging 6. Bank k occupies bits [3k+2:3k] of `bank_state_o`.
- R2: `cmd_i` codes are: NOP 0, activate 1, read 2, read with auto precharge 3, write 4, write with auto precharge 5, burst stop 6, precharge 7, precharge all 8, auto refresh 9, self refresh enter 10, self refresh exit 11, mode set 12, extended mode set 13, deep power-down enter 14, deep power-down exit 15. In power-on, only NOP, precharge all, extended mode set and mode set are legal, and mode set moves the device to ready.
- R3: Activate to an idle bank sets it to row open. Activate to any bank that is not idle is illegal.
- R4: Read or write, with or without auto precharge, is legal only to a bank in state 1, 2 or 3. The bank then shows the matching burst state for BURST_CYC cycles. A plain burst then returns to row open (1).
- R5: After a burst with auto precharge, the bank shows precharging (6) for PRE_CYC cycles and then returns to idle.
- R6: Burst stop is legal only while some bank is in a read burst (2). Every such bank returns to row open at once.
- R7: In ready, precharge sets the addressed bank to idle immediately, from any bank state, and precharge all sets every bank to idle.
- R8: Auto refresh, self refresh enter, mode set, extended mode set and deep power-down enter are legal in ready only when all banks are idle. Auto refresh holds the auto refresh state for REF_CYC cycles and then returns to ready. Any non-NOP command during auto refresh is illegal.
- R9: In ready, a low `cke_i` enters precharge power-down if all banks are idle, and otherwise enters active power-down. While in power-down, a high `cke_i` returns to ready. Any non-NOP command while `cke_i` is low in ready, or while in power-down, is illegal. `cke_i` has no effect in any other global state.
- R10: In self refresh, only NOP and self refresh exit are legal, and exit returns to ready. Self refresh exit in ready is illegal.
- R11: In deep power-down, only NOP and deep power-down exit are legal. Exit moves to power-on and raises `mode_clr_o` for exactly one cycle. Deep power-down exit in ready is illegal.
- R12: `illegal_o` is high for exactly the cycle after an illegal command, and an illegal command changes no state beyond the running burst, precharge and refresh counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 4 | Decoded command code |
| bank_i | input | $clog2(NBANK) | Target bank of the command |
| cke_i | input | 1 | Clock-enable level |
| bank_state_o | output | 3*NBANK | Packed per-bank state codes |
| glob_state_o | output | 3 | Global device state code |
| illegal_o | output | 1 | Previous command was illegal |
| mode_clr_o | output | 1 | Mode settings were lost (one cycle) |

## Verification
The bench builds the block with four banks, BURST_CYC = 2, PRE_CYC = 2 and REF_CYC = 3. These short counts bring every timed return within a handful of cycles. A plain burst ending, an auto-precharge burst passing through precharging, and an auto refresh ending can each be checked on the exact cycle of the change. A burst can also be stopped or overlapped while its counter is still running.

// File: rtl/mddr_pkg.sv
// Shared types for the mobile DRAM command tracker.
// Assumes: one command per clock, already decoded from the pins.
package mddr_pkg;

    typedef enum logic [3:0] {
        C_NOP  = 4'd0,  C_ACT  = 4'd1,  C_RD   = 4'd2,  C_RDA  = 4'd3,
        C_WR   = 4'd4,  C_WRA  = 4'd5,  C_BST  = 4'd6,  C_PRE  = 4'd7,
        C_PREA = 4'd8,  C_REF  = 4'd9,  C_SRE  = 4'd10, C_SRX  = 4'd11,
        C_MRS  = 4'd12, C_EMRS = 4'd13, C_DPE  = 4'd14, C_DPX  = 4'd15
    } cmd_e;

    typedef enum logic [2:0] {
        B_IDLE = 3'd0, B_ACT = 3'd1, B_RD = 3'd2, B_WR = 3'd3,
        B_RDA  = 3'd4, B_WRA = 3'd5, B_PRE = 3'd6
    } bank_e;

    typedef enum logic [2:0] {
        G_PWRON = 3'd0, G_READY = 3'd1, G_AREF = 3'd2, G_SREF = 3'd3,
        G_DPD   = 3'd4, G_PPD   = 3'd5, G_APD  = 3'd6
    } glob_e;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0, OP_OPEN = 3'd1, OP_RD = 3'd2, OP_RDAP = 3'd3,
        OP_WR   = 3'd4, OP_WRAP = 3'd5, OP_STOP = 3'd6, OP_CLOSE = 3'd7
    } bank_op_e;

    // True when a row is open and may take a column command.
    function automatic logic row_open(input bank_e s);
        return (s == B_ACT) || (s == B_RD) || (s == B_WR);
    endfunction

endpackage

// File: rtl/mddr_bank_track.sv
// Per-bank state tracker. It applies the operation granted by the command
// controller. With no operation, it runs the burst and precharge counters.
// Assumes: op_i is only non-NONE for a command already judged legal.
module mddr_bank_track
    import mddr_pkg::*;
#(
    parameter int BURST_CYC = 4,
    parameter int PRE_CYC   = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bank_op_e op_i,
    output bank_e    state_o
);
    localparam int MAXC = (BURST_CYC > PRE_CYC) ? BURST_CYC : PRE_CYC;
    localparam int TW   = $clog2(MAXC) + 1;
    localparam logic [TW-1:0] BURST_LOAD = TW'(BURST_CYC - 1);
    localparam logic [TW-1:0] PRE_LOAD   = TW'(PRE_CYC - 1);

    bank_e         st_q;
    logic [TW-1:0] tmr_q;

    // Bank state and occupancy counter: granted operation first, else timed progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= B_IDLE;
            tmr_q <= '0;
        end else begin
            case (op_i)
                OP_OPEN:  st_q <= B_ACT;
                OP_RD:    begin st_q <= B_RD;  tmr_q <= BURST_LOAD; end
                OP_RDAP:  begin st_q <= B_RDA; tmr_q <= BURST_LOAD; end
                OP_WR:    begin st_q <= B_WR;  tmr_q <= BURST_LOAD; end
                OP_WRAP:  begin st_q <= B_WRA; tmr_q <= BURST_LOAD; end
                OP_STOP:  begin st_q <= B_ACT; tmr_q <= '0; end
                OP_CLOSE: begin st_q <= B_IDLE; tmr_q <= '0; end
                default: begin
                    case (st_q)
                        B_RD, B_WR: begin
                            if (tmr_q == '0) st_q <= B_ACT;
                            else             tmr_q <= tmr_q - TW'(1);
                        end
                        B_RDA, B_WRA: begin
                            if (tmr_q == '0) begin
                                st_q  <= B_PRE;
                                tmr_q <= PRE_LOAD;
                            end else begin
                                tmr_q <= tmr_q - TW'(1);
                            end
                        end
                        B_PRE: begin
                            if (tmr_q == '0) st_q <= B_IDLE;
                            else             tmr_q <= tmr_q - TW'(1);
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/mddr_cmd_ctrl.sv
// Command legality and global state machine. It judges each command against
// the global state and the bank states, grants per-bank operations, and keeps
// the refresh occupancy counter.
// Assumes: bank_i < NBANK; the bank states are the registered outputs of the trackers.
module mddr_cmd_ctrl
    import mddr_pkg::*;
#(
    parameter int NBANK   = 4,
    parameter int BA_W    = 2,
    parameter int REF_CYC = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cmd_e            cmd_i,
    input  logic [BA_W-1:0] bank_i,
    input  logic            cke_i,
    input  bank_e           bank_st_i [NBANK],
    output bank_op_e        op_o      [NBANK],
    output glob_e           glob_o,
    output logic            illegal_o,
    output logic            mode_clr_o
);
    localparam int RW = $clog2(REF_CYC + 1);
    localparam logic [RW-1:0] REF_LOAD = RW'(REF_CYC - 1);

    glob_e         glob_q, glob_d;
    logic          legal;
    logic          illegal_q, mclr_q;
    logic [RW-1:0] rcnt_q;
    logic          all_idle, any_rd;
    bank_e         tgt_st;
    bank_op_e      ops_d [NBANK];

    // Summaries of the bank states used by the legality rules.
    always_comb begin
        all_idle = 1'b1;
        any_rd   = 1'b0;
        for (int i = 0; i < NBANK; i++) begin
            if (bank_st_i[i] != B_IDLE) all_idle = 1'b0;
            if (bank_st_i[i] == B_RD)   any_rd   = 1'b1;
        end
        tgt_st = bank_st_i[bank_i];
    end

    // Legality, next global state and granted bank operations.
    always_comb begin
        legal  = 1'b0;
        glob_d = glob_q;
        for (int i = 0; i < NBANK; i++) ops_d[i] = OP_NONE;
        case (glob_q)
            G_PWRON: begin
                case (cmd_i)
                    C_NOP, C_PREA, C_EMRS: legal = 1'b1;
                    C_MRS: begin legal = 1'b1; glob_d = G_READY; end
                    default: legal = 1'b0;
                endcase
            end
            G_READY: begin
                if (!cke_i) begin
                    legal  = (cmd_i == C_NOP);
                    glob_d = all_idle ? G_PPD : G_APD;
                end else begin
                    case (cmd_i)
                        C_NOP: legal = 1'b1;
                        C_ACT: if (tgt_st == B_IDLE) begin
                            legal = 1'b1;
                            ops_d[bank_i] = OP_OPEN;
                        end
                        C_RD, C_RDA, C_WR, C_WRA: if (row_open(tgt_st)) begin
                            legal = 1'b1;
                            case (cmd_i)
                                C_RD:    ops_d[bank_i] = OP_RD;
                                C_RDA:   ops_d[bank_i] = OP_RDAP;
                                C_WR:    ops_d[bank_i] = OP_WR;
                                default: ops_d[bank_i] = OP_WRAP;
                            endcase
                        end
                        C_BST: if (any_rd) begin
                            legal = 1'b1;
                            for (int i = 0; i < NBANK; i++)
                                if (bank_st_i[i] == B_RD) ops_d[i] = OP_STOP;
                        end
                        C_PRE: begin
                            legal = 1'b1;
                            ops_d[bank_i] = OP_CLOSE;
                        end
                        C_PREA: begin
                            legal = 1'b1;
                            for (int i = 0; i < NBANK; i++) ops_d[i] = OP_CLOSE;
                        end
                        C_REF: if (all_idle) begin legal = 1'b1; glob_d = G_AREF; end
                        C_SRE: if (all_idle) begin legal = 1'b1; glob_d = G_SREF; end
                        C_MRS, C_EMRS: legal = all_idle;
                        C_DPE: if (all_idle) begin legal = 1'b1; glob_d = G_DPD; end
                        default: legal = 1'b0;
                    endcase
                end
            end
            G_AREF: begin
                legal = (cmd_i == C_NOP);
                if (rcnt_q == '0) glob_d = G_READY;
            end
            G_SREF: begin
                legal = (cmd_i == C_NOP) || (cmd_i == C_SRX);
                if (cmd_i == C_SRX) glob_d = G_READY;
            end
            G_DPD: begin
                legal = (cmd_i == C_NOP) || (cmd_i == C_DPX);
                if (cmd_i == C_DPX) glob_d = G_PWRON;
            end
            G_PPD, G_APD: begin
                legal = (cmd_i == C_NOP);
                if (cke_i) glob_d = G_READY;
            end
            default: glob_d = G_PWRON;
        endcase
    end

    // Global state, illegal flag and mode-clear pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_q    <= G_PWRON;
            illegal_q <= 1'b0;
            mclr_q    <= 1'b0;
        end else begin
            glob_q    <= glob_d;
            illegal_q <= !legal;
            mclr_q    <= (glob_q == G_DPD) && (glob_d == G_PWRON);
        end
    end

    // Auto refresh occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt_q <= '0;
        end else if (glob_q == G_READY && glob_d == G_AREF) begin
            rcnt_q <= REF_LOAD;
        end else if (glob_q == G_AREF && rcnt_q != '0) begin
            rcnt_q <= rcnt_q - RW'(1);
        end
    end

    assign op_o       = ops_d;
    assign glob_o     = glob_q;
    assign illegal_o  = illegal_q;
    assign mode_clr_o = mclr_q;

endmodule

// File: rtl/mddr_cmd_tracker.sv
// Top level: one command controller plus one tracker per bank, with packed outputs.
// Assumes: NBANK >= 2; commands arrive decoded, one per clock.
module mddr_cmd_tracker
    import mddr_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int BURST_CYC = 4,
    parameter int PRE_CYC   = 3,
    parameter int REF_CYC   = 18,
    localparam int BA_W     = $clog2(NBANK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         cmd_i,
    input  logic [BA_W-1:0]    bank_i,
    input  logic               cke_i,
    output logic [3*NBANK-1:0] bank_state_o,
    output logic [2:0]         glob_state_o,
    output logic               illegal_o,
    output logic               mode_clr_o
);
    bank_e    bst  [NBANK];
    bank_op_e bops [NBANK];
    glob_e    glob;

    mddr_cmd_ctrl #(
        .NBANK  (NBANK),
        .BA_W   (BA_W),
        .REF_CYC(REF_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd_e'(cmd_i)),
        .bank_i    (bank_i),
        .cke_i     (cke_i),
        .bank_st_i (bst),
        .op_o      (bops),
        .glob_o    (glob),
        .illegal_o (illegal_o),
        .mode_clr_o(mode_clr_o)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        mddr_bank_track #(
            .BURST_CYC(BURST_CYC),
            .PRE_CYC  (PRE_CYC)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .op_i   (bops[g]),
            .state_o(bst[g])
        );
        assign bank_state_o[3*g +: 3] = bst[g];
    end

    assign glob_state_o = glob;

endmodule

// File: rtl/mddr_cmd_tracker_chk.sv
// Assertion checker bound to the tracker top; observes its ports only.
module mddr_cmd_tracker_chk
    import mddr_pkg::*;
#(
    parameter int NBANK = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3*NBANK-1:0] bank_state_o,
    input logic [2:0]         glob_state_o,
    input logic               mode_clr_o
);
    // R11: leaving deep power-down for power-on raises the clear pulse.
    a_r11_dpx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_state_o == G_PWRON && $past(glob_state_o) == G_DPD) |-> mode_clr_o);

    // R11: the clear pulse only follows a cycle spent in deep power-down.
    a_r11_clr_source: assert property (@(posedge clk) disable iff (!rst_n)
        mode_clr_o |-> ($past(glob_state_o) == G_DPD && glob_state_o == G_PWRON));

    // R10: self refresh is left only towards ready.
    a_r10_sref_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_state_o == G_SREF) |=> (glob_state_o == G_SREF || glob_state_o == G_READY));

    // R9: precharge power-down implies every bank idle.
    a_r9_ppd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_state_o == G_PPD) |-> (bank_state_o == '0));

    // R8: auto refresh implies every bank idle.
    a_r8_aref_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_state_o == G_AREF) |-> (bank_state_o == '0));

    for (genvar g = 0; g < NBANK; g++) begin : g_chk
        // R3: an idle bank can only stay idle or open a row.
        a_r3_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_state_o[3*g +: 3] == B_IDLE) |=>
            (bank_state_o[3*g +: 3] == B_IDLE || bank_state_o[3*g +: 3] == B_ACT));
    end

endmodule

bind mddr_cmd_tracker mddr_cmd_tracker_chk #(.NBANK(NBANK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_state_o(bank_state_o),
    .glob_state_o(glob_state_o),
    .mode_clr_o  (mode_clr_o)
);

// File: tb/sim_mddr_cmd_tracker.sv
`timescale 1ns/1ps
module sim_mddr_cmd_tracker;
    import mddr_pkg::*;

    typedef struct {
        logic [2:0]  g;
        logic [11:0] b;
        logic        ill;
        logic        mc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd = 4'd0;
    logic [1:0]  ba = 2'd0;
    logic        cke = 1'b1;
    logic [11:0] bank_state;
    logic [2:0]  glob_state;
    logic        illegal;
    logic        mode_clr;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    mddr_cmd_tracker #(
        .NBANK(4), .BURST_CYC(2), .PRE_CYC(2), .REF_CYC(3)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(ba), .cke_i(cke),
        .bank_state_o(bank_state), .glob_state_o(glob_state),
        .illegal_o(illegal), .mode_clr_o(mode_clr)
    );

    function automatic logic [11:0] bk4(input int b3, input int b2, input int b1, input int b0);
        return {3'(b3), 3'(b2), 3'(b1), 3'(b0)};
    endfunction

    // Driver: apply one command for one cycle and queue the expected outcome.
    task automatic drv(input cmd_e c, input int bk, input logic ck, input int g,
                       input logic [11:0] b, input logic ill, input logic mc, input string tag);
        exp_t e;
        @(negedge clk);
        cmd = c;
        ba  = 2'(bk);
        cke = ck;
        e.g = 3'(g); e.b = b; e.ill = ill; e.mc = mc; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: just after each edge, compare the outputs with the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (glob_state !== e.g || bank_state !== e.b ||
                    illegal !== e.ill || mode_clr !== e.mc) begin
                    n_bad++;
                    $display("FAIL %s: got g=%0d b=%h ill=%b mc=%b, exp g=%0d b=%h ill=%b mc=%b",
                             e.tag, glob_state, bank_state, illegal, mode_clr,
                             e.g, e.b, e.ill, e.mc);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang, exp completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (glob_state !== 3'd0 || bank_state !== 12'd0 || illegal !== 1'b0 || mode_clr !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got g=%0d b=%h ill=%b mc=%b, exp all zero",
                     glob_state, bank_state, illegal, mode_clr);
        end
        rst_n = 1'b1;

        drv(C_ACT,  0, 1, 0, 12'd0,          1, 0, "R2 act in power-on");
        drv(C_EMRS, 0, 1, 0, 12'd0,          0, 0, "R2 emrs in power-on");
        drv(C_MRS,  0, 1, 1, 12'd0,          0, 0, "R2 mrs to ready");
        drv(C_ACT,  0, 1, 1, bk4(0,0,0,1),   0, 0, "R3 open bank0");
        drv(C_ACT,  0, 1, 1, bk4(0,0,0,1),   1, 0, "R3 R12 reopen bank0");
        drv(C_RD,   1, 1, 1, bk4(0,0,0,1),   1, 0, "R4 read idle bank");
        drv(C_RD,   0, 1, 1, bk4(0,0,0,2),   0, 0, "R4 read start");
        drv(C_NOP,  0, 1, 1, bk4(0,0,0,2),   0, 0, "R4 read second cycle");
        drv(C_NOP,  0, 1, 1, bk4(0,0,0,1),   0, 0, "R4 read end");
        drv(C_WR,   0, 1, 1, bk4(0,0,0,3),   0, 0, "R4 write start");
        drv(C_BST,  0, 1, 1, bk4(0,0,0,3),   1, 0, "R6 stop during write");
        drv(C_NOP,  0, 1, 1, bk4(0,0,0,1),   0, 0, "R4 write end");
        drv(C_RD,   0, 1, 1, bk4(0,0,0,2),   0, 0, "R4 read again");
        drv(C_BST,  0, 1, 1, bk4(0,0,0,1),   0, 0, "R6 stop read");
        drv(C_REF,  0, 1, 1, bk4(0,0,0,1),   1, 0, "R8 refresh with open row");
        drv(C_NOP,  0, 0, 6, bk4(0,0,0,1),   0, 0, "R9 active power-down");
        drv(C_ACT,  1, 0, 6, bk4(0,0,0,1),   1, 0, "R9 R12 cmd in power-down");
        drv(C_NOP,  0, 1, 1, bk4(0,0,0,1),   0, 0, "R9 power-down exit");
        drv(C_ACT,  2, 1, 1, bk4(0,1,0,1),   0, 0, "R3 open bank2");
        drv(C_RDA,  2, 1, 1, bk4(0,4,0,1),   0, 0, "R5 read autoprecharge");
        drv(C_RD,   2, 1, 1, bk4(0,4,0,1),   1, 0, "R4 read during autoprecharge");
        drv(C_NOP,  0, 1, 1, bk4(0,6,0,1),   0, 0, "R5 precharging");
        drv(C_NOP,  0, 1, 1, bk4(0,6,0,1),   0, 0, "R5 precharging 2");
        drv(C_NOP,  0, 1, 1, bk4(0,0,0,1),   0, 0, "R5 back to idle");
        drv(C_WRA,  0, 1, 1, bk4(0,0,0,5),   0, 0, "R5 write autoprecharge");
        drv(C_NOP,  0, 1, 1, bk4(0,0,0,5),   0, 0, "R5 write burst 2");
        drv(C_NOP,  0, 1, 1, bk4(0,0,0,6),   0, 0, "R5 write precharging");
        drv(C_PRE,  0, 1, 1, bk4(0,0,0,0),   0, 0, "R7 precharge bank0");
        drv(C_ACT,  1, 1, 1, bk4(0,0,1,0),   0, 0, "R3 open bank1");
        drv(C_ACT,  3, 1, 1, bk4(1,0,1,0),   0, 0, "R3 open bank3");
        drv(C_PRE,  1, 1, 1, bk4(1,0,0,0),   0, 0, "R7 precharge bank1");
        drv(C_PREA, 0, 1, 1, 12'd0,          0, 0, "R7 precharge all");
        drv(C_NOP,  0, 0, 5, 12'd0,          0, 0, "R9 precharge power-down");
        drv(C_NOP,  0, 1, 1, 12'd0,          0, 0, "R9 exit");
        drv(C_REF,  0, 1, 2, 12'd0,          0, 0, "R8 refresh");
        drv(C_ACT,  0, 1, 2, 12'd0,          1, 0, "R8 cmd during refresh");
        drv(C_NOP,  0, 1, 2, 12'd0,          0, 0, "R8 refresh 3rd cycle");
        drv(C_NOP,  0, 1, 1, 12'd0,          0, 0, "R8 refresh done");
        drv(C_SRX,  0, 1, 1, 12'd0,          1, 0, "R10 exit in ready");
        drv(C_SRE,  0, 1, 3, 12'd0,          0, 0, "R10 self refresh");
        drv(C_MRS,  0, 0, 3, 12'd0,          1, 0, "R10 mrs in self refresh");
        drv(C_SRX,  0, 1, 1, 12'd0,          0, 0, "R10 self refresh exit");
        drv(C_DPX,  0, 1, 1, 12'd0,          1, 0, "R11 exit in ready");
        drv(C_ACT,  0, 1, 1, bk4(0,0,0,1),   0, 0, "R3 open bank0");
        drv(C_DPE,  0, 1, 1, bk4(0,0,0,1),   1, 0, "R8 deep pd with open row");
        drv(C_PRE,  0, 1, 1, 12'd0,          0, 0, "R7 close bank0");
        drv(C_DPE,  0, 1, 4, 12'd0,          0, 0, "R8 deep power-down");
        drv(C_SRX,  0, 1, 4, 12'd0,          1, 0, "R11 wrong exit");
        drv(C_DPX,  0, 1, 0, 12'd0,          0, 1, "R11 deep pd exit");
        drv(C_NOP,  0, 1, 0, 12'd0,          0, 0, "R11 pulse one cycle");
        drv(C_ACT,  0, 1, 0, 12'd0,          1, 0, "R2 act after deep pd");
        drv(C_MRS,  0, 1, 1, 12'd0,          0, 0, "R2 reinit");
        drv(C_NOP,  0, 1, 1, 12'd0,          0, 0, "R12 flag clears");

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule